// File: doc/BRIEF.md
# Burst Address Sequencer

This block turns one supplied address into the addresses of a burst of up to four accesses. On a clock edge where the load/advance control is low and the block is selected, it captures the external address and the command type (read or write), and it presents that address as the first beat. On each later edge where the control is high, it steps to the next beat. While it steps, it ignores the select and write-enable inputs and keeps reporting the command type it captured. Only the two lowest address bits move during a burst, and the upper bits stay as loaded.

The two low bits follow one of two orderings, picked by a mode input at load time. The interleaved order combines the starting low bits with the beat index by XOR. The linear order adds the beat index to the starting low bits and wraps within four. A memory controller or memory model uses the block as its address front end. It takes the current address, a valid flag, the captured command type and the beat index. Byte masks are not handled here: a write datapath has to present its byte selects on every beat.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held and after it is released, op_valid, op_write, burst_idx and addr_out are all zero.
- R2: An edge with ld_n low and sel high makes addr_out equal addr_in from the next cycle on, with burst_idx 0, op_valid 1 and op_write equal to the sampled wr_in (1 means write).
- R3: An edge with ld_n low and sel low clears op_valid and returns burst_idx to 0.
- R4: On an edge with ld_n high while op_valid is 1, sel and wr_in have no effect. op_write and addr_out bits above bit 1 keep their values.
- R5: With mode_il sampled as 1 at load, beat k presents low bits equal to start XOR k, where start is addr_in[1:0] at load.
- R6: With mode_il sampled as 0 at load, beat k presents low bits equal to (start + k) mod 4.
- R7: The ordering is fixed by mode_il at the load edge. Changes of mode_il during the advance edges of a burst do not change the sequence.
- R8: Each advance edge raises burst_idx by one modulo 4. An advance after beat 3 returns to beat 0 and to the loaded address, with no carry into bit 2.
- R9: An edge with ld_n high while op_valid is 0 leaves op_valid at 0 and leaves addr_out and burst_idx unchanged.
- R10: A load edge in the middle of a burst discards the old burst and starts a new one from the new address at beat 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_n | input | 1 | Low: load a new burst. High: advance the current burst |
| sel | input | 1 | Combined chip select, sampled only on load edges |
| wr_in | input | 1 | Command type, 1 = write, sampled only on a selected load |
| mode_il | input | 1 | 1 = interleaved order, 0 = linear order, sampled at load |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Address of the current beat |
| op_valid | output | 1 | A burst is active |
| op_write | output | 1 | Captured command type of the active burst |
| burst_idx | output | 2 | Beat index within the burst, 0 to 3 |

## Verification
The assertions assume that every input is a defined 0 or 1 level at each rising edge. They also assume that reset is held for at least one edge before any command, because the hold and step checks compare values across consecutive edges. The bench changes every input only on falling clock edges and starts in reset. It reads the outputs one falling edge after the rising edge they depend on. On advance edges it deliberately toggles sel, wr_in and mode_il, since the assertions have to hold for any input values there.

// File: rtl/bas_pkg.sv
package bas_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

endpackage

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
    import bas_pkg::*;
(
    input  beat_t beat_q,
    input  logic  load,
    input  logic  advance,
    output beat_t beat_d
);

    always_comb begin
        if (load) begin
            beat_d = '0;
        end else if (advance) begin
            beat_d = beat_q + beat_t'(1);
        end else begin
            beat_d = beat_q;
        end
    end

endmodule

// File: rtl/bas_order.sv
module bas_order
    import bas_pkg::*;
(
    input  beat_t  start_lo,
    input  beat_t  beat,
    input  order_e order,
    output beat_t  cur_lo
);

    beat_t lo_il;
    beat_t lo_lin;

    always_comb begin
        lo_il  = start_lo ^ beat;
        lo_lin = start_lo + beat;
        cur_lo = (order == ORD_INTERLEAVE) ? lo_il : lo_lin;
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              sel,
    input  logic              wr_in,
    input  logic              mode_il,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              op_valid,
    output logic              op_write,
    output logic [1:0]        burst_idx
);

    localparam int UP_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic              valid;
        logic              write;
        order_e            order;
        logic [ADDR_W-1:0] base;
        beat_t             beat;
    } seq_state_t;

    seq_state_t st_d, st_q;
    beat_t      beat_nxt;
    beat_t      lo_cur;
    logic       load_evt;
    logic       adv_evt;

    assign load_evt = !ld_n && sel;
    assign adv_evt  = ld_n && st_q.valid;

    bas_beat_ctr u_beat (
        .beat_q  (st_q.beat),
        .load    (!ld_n),
        .advance (adv_evt),
        .beat_d  (beat_nxt)
    );

    bas_order u_order (
        .start_lo (st_q.base[BEAT_W-1:0]),
        .beat     (st_q.beat),
        .order    (st_q.order),
        .cur_lo   (lo_cur)
    );

    always_comb begin
        st_d = st_q;
        if (load_evt) begin
            st_d.valid = 1'b1;
            st_d.write = wr_in;
            st_d.order = mode_il ? ORD_INTERLEAVE : ORD_LINEAR;
            st_d.base  = addr_in;
        end else if (!ld_n) begin
            st_d.valid = 1'b0;
        end
        st_d.beat = beat_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, write: 1'b0, order: ORD_LINEAR,
                      base: '0, beat: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_out  = {st_q.base[ADDR_W-1:BEAT_W], lo_cur};
    assign op_valid  = st_q.valid;
    assign op_write  = st_q.write;
    assign burst_idx = st_q.beat;

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && sel) |=> (op_valid && burst_idx == 2'd0)); // R2
    AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && !sel) |=> (!op_valid && burst_idx == 2'd0)); // R3
    AST_ADV_KEEP_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && op_valid) |=> $stable(op_write)); // R4
    AST_ADV_KEEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && op_valid) |=> $stable(addr_out[ADDR_W-1:BEAT_W])); // R4
    AST_ADV_KEEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && op_valid) |=> $stable(st_q.order)); // R7
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && op_valid) |=> (burst_idx == 2'($past(burst_idx) + 2'd1))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && !op_valid) |=> (!op_valid && $stable(addr_out) && $stable(burst_idx))); // R9

    localparam int UNUSED_UP = UP_W;

endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ld_n, sel, wr_in, mode_il;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic          op_valid, op_write;
    logic [1:0]    burst_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .sel(sel), .wr_in(wr_in),
        .mode_il(mode_il), .addr_in(addr_in), .addr_out(addr_out),
        .op_valid(op_valid), .op_write(op_write), .burst_idx(burst_idx)
    );

    function automatic logic [1:0] exp_lo(input logic [1:0] s, input logic [1:0] k,
                                          input logic il);
        return il ? (s ^ k) : 2'(s + k);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic l, input logic s, input logic w, input logic m,
                        input logic [AW-1:0] a);
        ld_n = l; sel = s; wr_in = w; mode_il = m; addr_in = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(1'b0, 1'b1, 1'b1, 1'b1, 20'hFFFFF);
        step(1'b0, 1'b1, 1'b1, 1'b1, 20'hFFFFF);
        chk("R1 valid", 32'(op_valid), 0);
        chk("R1 write", 32'(op_write), 0);
        chk("R1 idx", 32'(burst_idx), 0);
        chk("R1 addr", 32'(addr_out), 0);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk("R1 valid after release", 32'(op_valid), 0);
        chk("R1 addr after release", 32'(addr_out), 0);
    endtask

    task automatic t_order(input logic il, input string req);
        for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] a = {18'h2B5C0 + 18'(s), 2'(s)};
            step(1'b0, 1'b1, il, il, a);
            chk("R2 load addr", 32'(addr_out), 32'(a));
            chk("R2 idx", 32'(burst_idx), 0);
            chk("R2 valid", 32'(op_valid), 1);
            chk("R2 write", 32'(op_write), 32'(il));
            for (int k = 1; k < 4; k++) begin
                step(1'b1, 1'b1, 1'b0, il, '0);
                chk(req, 32'(addr_out), 32'({a[AW-1:2], exp_lo(2'(s), 2'(k), il)}));
                chk("R8 idx", 32'(burst_idx), 32'(k));
            end
            step(1'b1, 1'b1, 1'b0, il, '0);
            chk("R8 wrap addr", 32'(addr_out), 32'(a));
            chk("R8 wrap idx", 32'(burst_idx), 0);
        end
    endtask

    task automatic t_ignore();
        logic [AW-1:0] a = 20'h81237;
        step(1'b0, 1'b1, 1'b1, 1'b0, a);
        step(1'b1, 1'b0, 1'b0, 1'b0, 20'h00000);
        chk("R4 sel ignored", 32'(op_valid), 1);
        chk("R4 write held", 32'(op_write), 1);
        chk("R4 upper held", 32'(addr_out), 32'({a[AW-1:2], 2'b00}));
        step(1'b1, 1'b1, 1'b0, 1'b0, 20'hFFFFF);
        chk("R4 addr_in ignored", 32'(addr_out), 32'({a[AW-1:2], 2'b01}));
        chk("R4 write held", 32'(op_write), 1);
    endtask

    task automatic t_mode_freeze();
        logic [AW-1:0] a = 20'h40001;
        step(1'b0, 1'b1, 1'b0, 1'b1, a);
        step(1'b1, 1'b1, 1'b0, 1'b0, '0);
        chk("R7 beat1", 32'(addr_out[1:0]), 32'(2'b00));
        step(1'b1, 1'b1, 1'b0, 1'b0, '0);
        chk("R7 beat2", 32'(addr_out[1:0]), 32'(2'b11));
        step(1'b0, 1'b1, 1'b0, 1'b0, a);
        step(1'b1, 1'b1, 1'b0, 1'b1, '0);
        chk("R7 linear kept", 32'(addr_out[1:0]), 32'(2'b10));
    endtask

    task automatic t_deselect_idle();
        step(1'b0, 1'b1, 1'b0, 1'b0, 20'h12342);
        step(1'b1, 1'b0, 1'b0, 1'b0, '0);
        step(1'b0, 1'b0, 1'b1, 1'b0, 20'h99999);
        chk("R3 valid cleared", 32'(op_valid), 0);
        chk("R3 idx zero", 32'(burst_idx), 0);
        chk("R9 idle addr ref", 32'(addr_out), 32'(20'h12342));
        step(1'b1, 1'b1, 1'b1, 1'b1, 20'h55555);
        chk("R9 idle valid", 32'(op_valid), 0);
        chk("R9 idle addr", 32'(addr_out), 32'(20'h12342));
        chk("R9 idle idx", 32'(burst_idx), 0);
    endtask

    task automatic t_reload();
        step(1'b0, 1'b1, 1'b0, 1'b0, 20'h0A0A2);
        step(1'b1, 1'b1, 1'b0, 1'b0, '0);
        step(1'b0, 1'b1, 1'b1, 1'b1, 20'h7F7F3);
        chk("R10 new addr", 32'(addr_out), 32'(20'h7F7F3));
        chk("R10 idx", 32'(burst_idx), 0);
        chk("R10 write", 32'(op_write), 1);
        step(1'b1, 1'b1, 1'b0, 1'b0, '0);
        chk("R10 next beat", 32'(addr_out), 32'(20'h7F7F2));
    endtask

    initial begin
        rst_n = 1'b0; ld_n = 1'b1; sel = 1'b0; wr_in = 1'b0; mode_il = 1'b0;
        addr_in = '0;
        @(negedge clk);
        t_reset();
        t_order(1'b1, "R5 interleaved");
        t_order(1'b0, "R6 linear");
        t_ignore();
        t_mode_freeze();
        t_deselect_idle();
        t_reload();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule